// File: doc/BRIEF.md
# Multi-Mode Asynchronous Word Transfer Controller

This block moves a single parallel data word across a link to a partner unit that has no clock in common with it. The only coordination between the two ends is a set of control lines. A two-bit mode input picks one of four schemes. Two are timed: a source strobe whose width is fixed, or a destination strobe whose width is fixed. The other two are four-phase handshakes: a source request that the destination acknowledges, or a destination request that the source answers with a data-ready line. A role input says whether this end is the source or the destination of the word, so one design can sit at either end.

A transfer begins when `start` is pulsed while the controller is idle. The controller samples mode, role and, for a source, the outgoing word at that moment, and ignores `start` until the transfer is over. Each incoming control line passes through a two-flop synchronizer before the sequencer uses it. Each finished transfer produces a `done` pulse one cycle long. A destination exposes the captured word on `rd_data`.

Top module: `async_xfer_ctrl`

## Requirements
- R1: While reset is active and right after it is released, every output (`stb_o`, `ack_o`, `rdy_o`, `done`, `lnk_dout`, `rd_data`) is zero.
- R2: In mode 0 (source-strobed) with role 0 (source), the word appears on `lnk_dout` one cycle before `stb_o` rises. `stb_o` then stays high for exactly N cycles, and `done` rises in the cycle `stb_o` falls. N is the delay input, or 1 when the delay is zero.
- R3: In mode 1 (destination-strobed) with role 1 (destination), `stb_o` is high for exactly N cycles. `rd_data` holds the value `lnk_din` had in the last of those cycles.
- R4: A delay input of zero gives a strobe exactly one cycle long.
- R5: In mode 2 (source handshake with acknowledge) with role 0, `stb_o` stays high until the synchronized `ack_i` is seen high. After it falls, `done` is withheld for as long as `ack_i` stays high.
- R6: In mode 3 (destination request, data-ready answer) with role 0, `rdy_o` rises only after `stb_i` rises, stays high while `stb_i` is high, and falls in the same cycle that `done` pulses.
- R7: In mode 0 with role 1, a started controller waits for `stb_i`, captures `lnk_din` while it is high, and pulses `done` after `stb_i` falls.
- R8: In mode 2 with role 1, the controller captures `lnk_din` when `stb_i` is seen high and raises `ack_o`. It holds `ack_o` until `stb_i` falls, then drops it together with `done`.
- R9: In mode 3 with role 1, `stb_o` rises and stays high until `rdy_i` is seen high. The word is captured as `stb_o` drops, and `done` waits until `rdy_i` has fallen.
- R10: A change on an incoming control line affects any output no earlier than the third rising clock edge after the change.
- R11: `done` is high for exactly one cycle per completed transfer.
- R12: `start` has no effect while a transfer is in progress. `lnk_dout` changes only while all three outgoing control lines are low.
- R13: At most one of `stb_o`, `ack_o`, `rdy_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| mode | input | 2 | 0 source strobe, 1 destination strobe, 2 acknowledge handshake, 3 data-ready handshake |
| role | input | 1 | 0 source end, 1 destination end |
| delay_cfg | input | DLY_W | Strobe width in cycles for timed modes (0 means 1) |
| wr_data | input | W | Word to send when acting as source |
| rd_data | output | W | Word captured when acting as destination |
| done | output | 1 | One-cycle completion pulse |
| lnk_dout | output | W | Data lines driven toward the partner |
| lnk_din | input | W | Data lines from the partner |
| stb_o | output | 1 | Strobe or request driven by this end |
| stb_i | input | 1 | Strobe or request from the partner |
| ack_o | output | 1 | Acknowledge driven by this end |
| ack_i | input | 1 | Acknowledge from the partner |
| rdy_o | output | 1 | Data-ready driven by this end |
| rdy_i | input | 1 | Data-ready from the partner |

## Verification
Each of the eight mode and role pairs is run against a partner modelled in the bench. The bench holds responses for different lengths so that a wrong wait condition shows up as an early edge or an early `done`. Timed strobes are run with delays of zero, one and several cycles, which separates a correct count from an off-by-one or a missing zero clamp. For the destination modes, the partner changes the data lines before and after the capture window, which shows whether the word is sampled at the right moment. A `start` issued in the middle of a handshake, and output sampling one and two edges after a partner edge, expose a start that is not ignored and a synchronizer with a missing stage.

// File: rtl/async_xfer_pkg.sv
package async_xfer_pkg;

  typedef enum logic [1:0] {
    XM_SRC_STB = 2'd0,
    XM_DST_STB = 2'd1,
    XM_SRC_HSK = 2'd2,
    XM_DST_HSK = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ASSERT,
    ST_PEER_HI,
    ST_HOLD,
    ST_PEER_LO,
    ST_DONE
  } xfer_state_e;

  localparam int LN_STB   = 0;
  localparam int LN_ACK   = 1;
  localparam int LN_RDY   = 2;
  localparam int LN_COUNT = 3;

endpackage

// File: rtl/async_xfer_sync.sv
module async_xfer_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain <= {chain[STAGES-2:0], d[g]};
        end
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/async_xfer_timer.sv
module async_xfer_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [DLY_W-1:0] dly,
  output logic             expire
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic [DLY_W-1:0] load_val;
  logic             cnt_en;

  // zero delay is clamped to a single cycle
  assign load_val = (dly == '0) ? ONE : dly;
  assign cnt_en   = load | (dec & (cnt_q != '0));

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == ONE);

endmodule

// File: rtl/async_xfer_fsm.sv
module async_xfer_fsm
  import async_xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode_i,
  input  logic                role_i,
  input  logic [LN_COUNT-1:0] in_s,
  input  logic                expire,
  output logic                accept,
  output logic                tmr_dec,
  output logic                cap_en,
  output logic                stb_o,
  output logic                ack_o,
  output logic                rdy_o,
  output logic                done
);

  xfer_state_e state_q, state_d;
  xfer_mode_e  mode_q, mode_n;
  logic        role_q, role_n;
  logic        initiator, hsk, is_dst, peer;
  int unsigned peer_sel;
  logic        line_n, init_n;
  logic        stb_d, ack_d, rdy_d, done_d;

  assign initiator = (role_q == mode_q[0]);
  assign hsk       = mode_q[1];
  assign is_dst    = role_q;

  always_comb begin
    if (!role_q && mode_q == XM_SRC_HSK) begin
      peer_sel = LN_ACK;
    end else if (role_q && mode_q == XM_DST_HSK) begin
      peer_sel = LN_RDY;
    end else begin
      peer_sel = LN_STB;
    end
  end

  assign peer = in_s[peer_sel];

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    tmr_dec = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = ST_LEAD;
        end
      end
      ST_LEAD: begin
        state_d = initiator ? ST_ASSERT : ST_PEER_HI;
      end
      ST_ASSERT: begin
        if (!hsk) begin
          tmr_dec = 1'b1;
          if (expire) begin
            cap_en  = is_dst;
            state_d = ST_DONE;
          end
        end else if (peer) begin
          cap_en  = is_dst;
          state_d = ST_PEER_LO;
        end
      end
      ST_PEER_HI: begin
        if (peer) begin
          cap_en  = is_dst;
          state_d = hsk ? ST_HOLD : ST_PEER_LO;
        end
      end
      ST_HOLD: begin
        if (!peer) begin
          state_d = ST_DONE;
        end
      end
      ST_PEER_LO: begin
        if (!peer) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // line routing from the upcoming state, registered below
  assign mode_n = accept ? xfer_mode_e'(mode_i) : mode_q;
  assign role_n = accept ? role_i : role_q;
  assign init_n = (role_n == mode_n[0]);
  assign line_n = (state_d == ST_ASSERT) || (state_d == ST_HOLD);
  assign stb_d  = line_n && init_n;
  assign ack_d  = line_n && !init_n && role_n && (mode_n == XM_SRC_HSK);
  assign rdy_d  = line_n && !init_n && !role_n && (mode_n == XM_DST_HSK);
  assign done_d = (state_d == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stb_o   <= 1'b0;
      ack_o   <= 1'b0;
      rdy_o   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_o   <= stb_d;
      ack_o   <= ack_d;
      rdy_o   <= rdy_d;
      done    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XM_SRC_STB;
      role_q <= 1'b0;
    end else if (accept) begin
      mode_q <= xfer_mode_e'(mode_i);
      role_q <= role_i;
    end
  end

endmodule

// File: rtl/async_xfer_ctrl.sv
module async_xfer_ctrl
  import async_xfer_pkg::*;
#(
  parameter int W        = 8,
  parameter int DLY_W    = 8,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             role,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  output logic             done,
  output logic [W-1:0]     lnk_dout,
  input  logic [W-1:0]     lnk_din,
  output logic             stb_o,
  input  logic             stb_i,
  output logic             ack_o,
  input  logic             ack_i,
  output logic             rdy_o,
  input  logic             rdy_i
);

  logic [LN_COUNT-1:0] in_raw, in_s;
  logic                accept, tmr_dec, cap_en, expire;
  logic                dout_en;

  always_comb begin
    in_raw         = '0;
    in_raw[LN_STB] = stb_i;
    in_raw[LN_ACK] = ack_i;
    in_raw[LN_RDY] = rdy_i;
  end

  async_xfer_sync #(
    .STAGES(SYNC_STG),
    .LANES (LN_COUNT)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (in_raw),
    .q    (in_s)
  );

  async_xfer_timer #(
    .DLY_W(DLY_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .dec   (tmr_dec),
    .dly   (delay_cfg),
    .expire(expire)
  );

  async_xfer_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode_i (mode),
    .role_i (role),
    .in_s   (in_s),
    .expire (expire),
    .accept (accept),
    .tmr_dec(tmr_dec),
    .cap_en (cap_en),
    .stb_o  (stb_o),
    .ack_o  (ack_o),
    .rdy_o  (rdy_o),
    .done   (done)
  );

  assign dout_en = accept & ~role;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lnk_dout <= '0;
    end else if (dout_en) begin
      lnk_dout <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (cap_en) begin
      rd_data <= lnk_din;
    end
  end

endmodule

// File: rtl/async_xfer_ctrl_chk.sv
module async_xfer_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         done,
  input logic         stb_o,
  input logic         ack_o,
  input logic         rdy_o,
  input logic [W-1:0] lnk_dout
);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_o, ack_o, rdy_o}));

  a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o || rdy_o) |-> $stable(lnk_dout));

  a_r12_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lnk_dout) |-> !(stb_o || ack_o || rdy_o));

  // covers R6 and R8: a response line drops only as the transfer completes
  a_r8_resp_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) || $fell(rdy_o)) |-> done);

endmodule

bind async_xfer_ctrl async_xfer_ctrl_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .stb_o   (stb_o),
  .ack_o   (ack_o),
  .rdy_o   (rdy_o),
  .lnk_dout(lnk_dout)
);

// File: tb/async_xfer_ctrl_tb.sv
module async_xfer_ctrl_tb;

  localparam int W     = 8;
  localparam int DLY_W = 8;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [1:0]       mode;
  logic             role;
  logic [DLY_W-1:0] delay_cfg;
  logic [W-1:0]     wr_data;
  logic [W-1:0]     rd_data;
  logic             done;
  logic [W-1:0]     lnk_dout;
  logic [W-1:0]     lnk_din;
  logic             stb_o, stb_i, ack_o, ack_i, rdy_o, rdy_i;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  async_xfer_ctrl #(.W(W), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .role(role),
    .delay_cfg(delay_cfg), .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .lnk_dout(lnk_dout), .lnk_din(lnk_din),
    .stb_o(stb_o), .stb_i(stb_i), .ack_o(ack_o), .ack_i(ack_i),
    .rdy_o(rdy_o), .rdy_i(rdy_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic probe(input int sel);
    case (sel)
      0:       return stb_o;
      1:       return ack_o;
      2:       return rdy_o;
      default: return done;
    endcase
  endfunction

  task automatic wait_for(input int sel, input logic val, input string req);
    bit seen = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (probe(sel) == val) begin
        seen = 1;
        break;
      end
    end
    chk(seen, req, "wait for line", int'(!val), int'(val));
  endtask

  task automatic launch(input logic [1:0] m, input logic r,
                        input logic [W-1:0] d, input int dly);
    @(negedge clk);
    mode = m; role = r; wr_data = d; delay_cfg = DLY_W'(dly); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic done_once(input string req);
    wait_for(3, 1'b1, req);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done width", int'(done), 0);
  endtask

  task automatic t_reset;
    chk({stb_o, ack_o, rdy_o, done} == 4'b0, "R1", "control lines", {stb_o, ack_o, rdy_o, done}, 0);
    chk(lnk_dout == '0 && rd_data == '0, "R1", "data outputs", int'(lnk_dout) + int'(rd_data), 0);
  endtask

  task automatic t_src_strobe(input int dly, input logic [W-1:0] d, input string req);
    int hi = 0;
    int exp_n = (dly == 0) ? 1 : dly;
    bit fin = 0;
    launch(2'd0, 1'b0, d, dly);
    chk(lnk_dout == d && stb_o == 1'b0, "R2", "data leads strobe", int'(lnk_dout), int'(d));
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin
        fin = 1;
        chk(stb_o == 1'b0, "R2", "strobe low at done", int'(stb_o), 0);
        break;
      end
      if (stb_o) begin
        hi++;
        if (lnk_dout != d) chk(0, "R12", "data stable", int'(lnk_dout), int'(d));
      end
    end
    chk(fin, "R2", "done seen", int'(fin), 1);
    chk(hi == exp_n, req, "strobe width", hi, exp_n);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done width", int'(done), 0);
  endtask

  task automatic t_dst_strobe(input int dly, input logic [W-1:0] d, input string req);
    int hi = 0;
    int exp_n = (dly == 0) ? 1 : dly;
    lnk_din = d;
    launch(2'd1, 1'b1, 8'h00, dly);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) break;
      if (stb_o) hi++;
    end
    lnk_din = ~d;
    chk(hi == exp_n, req, "dest strobe width", hi, exp_n);
    chk(rd_data == d, "R3", "captured word", int'(rd_data), int'(d));
    @(negedge clk);
    chk(done == 1'b0 && rd_data == d, "R11", "done width / word held", int'(done), 0);
  endtask

  task automatic t_src_ack(input logic [W-1:0] d);
    launch(2'd2, 1'b0, d, 0);
    wait_for(0, 1'b1, "R5");
    chk(lnk_dout == d, "R5", "data with request", int'(lnk_dout), int'(d));
    // R12: start during transfer is ignored
    mode = 2'd1; role = 1'b1; wr_data = ~d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(stb_o == 1'b1 && lnk_dout == d, "R12", "start ignored", int'(lnk_dout), int'(d));
    chk(done == 1'b0, "R5", "no done before ack", int'(done), 0);
    ack_i = 1'b1;
    @(negedge clk);
    chk(stb_o == 1'b1, "R10", "request after 1 edge", int'(stb_o), 1);
    @(negedge clk);
    chk(stb_o == 1'b1, "R10", "request after 2 edges", int'(stb_o), 1);
    @(negedge clk);
    chk(stb_o == 1'b0, "R5", "request drops after ack", int'(stb_o), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done) chk(0, "R5", "done while ack high", 1, 0);
    end
    ack_i = 1'b0;
    done_once("R5");
  endtask

  task automatic t_src_rdy(input logic [W-1:0] d);
    launch(2'd3, 1'b0, d, 0);
    repeat (4) @(negedge clk);
    chk(rdy_o == 1'b0, "R6", "no ready without request", int'(rdy_o), 0);
    stb_i = 1'b1;
    wait_for(2, 1'b1, "R6");
    chk(lnk_dout == d, "R6", "data with ready", int'(lnk_dout), int'(d));
    repeat (4) @(negedge clk);
    chk(rdy_o == 1'b1 && done == 1'b0, "R6", "ready held", int'(rdy_o), 1);
    stb_i = 1'b0;
    wait_for(3, 1'b1, "R6");
    chk(rdy_o == 1'b0, "R6", "ready low with done", int'(rdy_o), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done width", int'(done), 0);
  endtask

  task automatic t_dst_passive(input logic [W-1:0] d);
    lnk_din = ~d;
    launch(2'd0, 1'b1, 8'h00, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R7", "waits for strobe", int'(done), 0);
    lnk_din = d;
    stb_i = 1'b1;
    repeat (6) @(negedge clk);
    stb_i = 1'b0;
    @(negedge clk);
    lnk_din = ~d;
    done_once("R7");
    chk(rd_data == d, "R7", "captured word", int'(rd_data), int'(d));
  endtask

  task automatic t_dst_ack(input logic [W-1:0] d);
    launch(2'd2, 1'b1, 8'h00, 0);
    lnk_din = d;
    stb_i = 1'b1;
    wait_for(1, 1'b1, "R8");
    chk(rd_data == d, "R8", "captured at ack", int'(rd_data), int'(d));
    lnk_din = ~d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!ack_o || done) chk(0, "R8", "ack held", int'(ack_o), 1);
      if (stb_o || rdy_o) chk(0, "R13", "one line only", int'({stb_o, rdy_o}), 0);
    end
    stb_i = 1'b0;
    wait_for(3, 1'b1, "R8");
    chk(ack_o == 1'b0 && rd_data == d, "R8", "ack dropped with done", int'(ack_o), 0);
  endtask

  task automatic t_dst_rdy(input logic [W-1:0] d);
    lnk_din = ~d;
    launch(2'd3, 1'b1, 8'h00, 0);
    wait_for(0, 1'b1, "R9");
    repeat (4) @(negedge clk);
    chk(stb_o == 1'b1, "R9", "request waits for ready", int'(stb_o), 1);
    chk(ack_o == 1'b0 && rdy_o == 1'b0, "R13", "one line only", int'({ack_o, rdy_o}), 0);
    lnk_din = d;
    rdy_i = 1'b1;
    wait_for(0, 1'b0, "R9");
    lnk_din = ~d;
    chk(rd_data == d, "R9", "captured word", int'(rd_data), int'(d));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) chk(0, "R9", "done while ready high", 1, 0);
    end
    rdy_i = 1'b0;
    done_once("R9");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; role = 1'b0;
    delay_cfg = '0; wr_data = '0; lnk_din = '0;
    stb_i = 1'b0; ack_i = 1'b0; rdy_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({stb_o, ack_o, rdy_o, done} == 4'b0, "R1", "during reset", {stb_o, ack_o, rdy_o, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_src_strobe(3, 8'hA5, "R2");
    t_src_strobe(0, 8'h3C, "R4");
    t_src_strobe(1, 8'h81, "R2");
    t_dst_strobe(4, 8'h5A, "R3");
    t_dst_strobe(0, 8'hC3, "R4");
    t_src_ack(8'h96);
    t_src_rdy(8'h7E);
    t_dst_passive(8'h1F);
    t_dst_ack(8'hE4);
    t_dst_rdy(8'h42);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule